// File: doc/BRIEF.md
# Mode-Selectable LED Frame Refresh Buffer

This block sits between a byte-wide register write port and the per-dot PWM duty inputs of an LED matrix driver. For every dot it keeps two 16-bit registers: a write buffer, which the write port fills, and a display buffer, which drives the duty output. A two-bit mode input decides how a write reaches the display.

In live mode, an 8-bit write goes straight to the display, so software can refresh just the dots that changed. In the two framed modes, writes collect in the write buffer while the display holds the previous frame. A qualified VSYNC pulse then copies every dot to the display on one clock edge. The two framed modes differ in resolution: one takes 8-bit duty values, the other 16-bit values written as two bytes. The VSYNC input is synchronised into the clock domain, and a pulse counts only if it stays high long enough. Several drivers that share one VSYNC line therefore change frames together.

Top module: `frame_refresh_buf`

## Requirements
- R1: While rst_ni is low, and after it is released, every write buffer entry and every display entry is zero.
- R2: In live mode (mode_i = 1, with the reserved value 0 treated the same), a write of byte D to address A < NUM_DOTS sets dot A's duty output to {D, 8'h00} on the clock edge that accepts the write.
- R3: In live mode a write changes only the addressed dot's duty output. All other dots keep their values.
- R4: In the framed modes (mode_i = 2 for 8-bit, mode_i = 3 for 16-bit), writes change only the write buffer. The duty outputs stay constant until a frame event.
- R5: On a frame event, all NUM_DOTS display entries take the write buffer contents on the same clock edge.
- R6: vsync_i passes through a two-flop synchroniser. A frame event fires exactly once per pulse, on the cycle in which the synchronised input has been high for VS_MIN_W cycles. A pulse shorter than VS_MIN_W input cycles causes no event.
- R7: In 16-bit mode, dot = address >> 1. An even address writes bits 7:0 and an odd address writes bits 15:8. The other byte of the dot is unchanged.
- R8: Changing mode_i leaves the display unchanged. Live-mode writes also update the write buffer, so a later frame copy shows the same value.
- R9: VSYNC pulses that arrive in live mode cause no copy.
- R10: Writes to out-of-range dots (address >= NUM_DOTS in 8-bit modes) are ignored.
- R11: If a write and a frame event fall in the same cycle, the copy uses the write buffer contents from before that write. The written value appears at the next frame event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Refresh mode: 0/1 live 8-bit, 2 framed 8-bit, 3 framed 16-bit |
| wr_en_i | input | 1 | Write strobe, one byte per cycle |
| wr_addr_i | input | ADDR_W (6) | Byte address |
| wr_data_i | input | 8 | Write byte |
| vsync_i | input | 1 | Asynchronous frame sync input |
| duty_o | output | NUM_DOTS*16 (512) | Display duty values; dot i occupies bits 16*i+15 : 16*i |

## Verification
A write to the write buffer and the whole-frame copy can land on the same clock edge. The bench provokes this by holding VSYNC high and timing a framed write to reach the edge where the qualifier reaches VS_MIN_W. It then checks that the display shows the older write buffer value for that dot, and that the next qualified pulse brings out the new value. The bench also checks that a second write made while the same long pulse is still high is held back, which confirms that one pulse triggers only one copy.

// File: rtl/frb_pkg.sv
package frb_pkg;
  typedef enum logic [1:0] {
    MODE_RSVD  = 2'd0,
    MODE_LIVE  = 2'd1,
    MODE_FRM8  = 2'd2,
    MODE_FRM16 = 2'd3
  } refresh_mode_e;

  localparam int DUTY_W = 16;
  typedef logic [DUTY_W-1:0] duty_t;
endpackage

// File: rtl/frb_vsync_qual.sv
module frb_vsync_qual #(
  parameter int VS_MIN_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vsync_i,
  output logic pulse_o
);
  localparam int CW = $clog2(VS_MIN_W + 1);
  localparam logic [CW-1:0] CNT_SAT = CW'(VS_MIN_W);
  localparam logic [CW-1:0] CNT_HIT = CW'(VS_MIN_W - 1);

  logic s1_q, s2_q;
  logic [CW-1:0] hi_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= vsync_i;
      s2_q <= s1_q;
    end
  end

  // counts high cycles of the synced input, saturates so the hit is seen once
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                hi_cnt_q <= '0;
    else if (!s2_q)             hi_cnt_q <= '0;
    else if (hi_cnt_q != CNT_SAT) hi_cnt_q <= hi_cnt_q + 1'b1;
  end

  assign pulse_o = s2_q && (hi_cnt_q == CNT_HIT);
endmodule

// File: rtl/frb_wr_decode.sv
module frb_wr_decode
  import frb_pkg::*;
#(
  parameter int NUM_DOTS = 32,
  parameter int ADDR_W   = $clog2(2 * NUM_DOTS)
) (
  input  refresh_mode_e       mode_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [7:0]          wr_data_i,
  output logic [NUM_DOTS-1:0] dot_sel_o,
  output logic                lo_en_o,
  output logic                hi_en_o,
  output logic [7:0]          lo_byte_o,
  output logic [7:0]          hi_byte_o
);
  localparam logic [ADDR_W:0] DOT_LIM = (ADDR_W+1)'(NUM_DOTS);

  logic              wide;
  logic [ADDR_W-1:0] dot_idx;
  logic              in_range;

  always_comb begin
    wide     = (mode_i == MODE_FRM16);
    dot_idx  = wide ? (wr_addr_i >> 1) : wr_addr_i;
    in_range = ({1'b0, dot_idx} < DOT_LIM);
    if (wide) begin
      lo_en_o   = ~wr_addr_i[0];
      hi_en_o   = wr_addr_i[0];
      lo_byte_o = wr_data_i;
      hi_byte_o = wr_data_i;
    end else begin
      // 8-bit duty sits in the upper byte, lower byte forced to zero
      lo_en_o   = 1'b1;
      hi_en_o   = 1'b1;
      lo_byte_o = 8'h00;
      hi_byte_o = wr_data_i;
    end
  end

  for (genvar i = 0; i < NUM_DOTS; i++) begin : g_sel
    assign dot_sel_o[i] = wr_en_i && in_range && (dot_idx == ADDR_W'(i));
  end
endmodule

// File: rtl/frb_dot_bank.sv
module frb_dot_bank
  import frb_pkg::*;
#(
  parameter int NUM_DOTS = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_DOTS-1:0]        dot_sel_i,
  input  logic                       lo_en_i,
  input  logic                       hi_en_i,
  input  logic [7:0]                 lo_byte_i,
  input  logic [7:0]                 hi_byte_i,
  input  logic                       live_i,
  input  logic                       frame_evt_i,
  output logic [NUM_DOTS*DUTY_W-1:0] shadow_o,
  output logic [NUM_DOTS*DUTY_W-1:0] active_o
);
  for (genvar i = 0; i < NUM_DOTS; i++) begin : g_dot
    duty_t shadow_q, active_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow_q <= '0;
      end else if (dot_sel_i[i]) begin
        if (lo_en_i) shadow_q[7:0]  <= lo_byte_i;
        if (hi_en_i) shadow_q[15:8] <= hi_byte_i;
      end
    end

    // frame copy reads the pre-write shadow value
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    active_q <= '0;
      else if (frame_evt_i)           active_q <= shadow_q;
      else if (live_i && dot_sel_i[i]) active_q <= {hi_byte_i, lo_byte_i};
    end

    assign shadow_o[i*DUTY_W +: DUTY_W] = shadow_q;
    assign active_o[i*DUTY_W +: DUTY_W] = active_q;
  end
endmodule

// File: rtl/frame_refresh_buf.sv
module frame_refresh_buf
  import frb_pkg::*;
#(
  parameter int NUM_DOTS = 32,
  parameter int VS_MIN_W = 4,
  parameter int ADDR_W   = $clog2(2 * NUM_DOTS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [1:0]                 mode_i,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [7:0]                 wr_data_i,
  input  logic                       vsync_i,
  output logic [NUM_DOTS*DUTY_W-1:0] duty_o
);
  refresh_mode_e mode;
  logic          live, framed, vs_pulse, frame_evt;
  logic [NUM_DOTS-1:0] dot_sel;
  logic          lo_en, hi_en;
  logic [7:0]    lo_byte, hi_byte;
  logic [NUM_DOTS*DUTY_W-1:0] shadow_flat;

  assign mode      = refresh_mode_e'(mode_i);
  assign framed    = (mode == MODE_FRM8) || (mode == MODE_FRM16);
  assign live      = ~framed;
  assign frame_evt = vs_pulse && framed;

  frb_vsync_qual #(.VS_MIN_W(VS_MIN_W)) u_vsq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vsync_i (vsync_i),
    .pulse_o (vs_pulse)
  );

  frb_wr_decode #(.NUM_DOTS(NUM_DOTS), .ADDR_W(ADDR_W)) u_dec (
    .mode_i    (mode),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .dot_sel_o (dot_sel),
    .lo_en_o   (lo_en),
    .hi_en_o   (hi_en),
    .lo_byte_o (lo_byte),
    .hi_byte_o (hi_byte)
  );

  frb_dot_bank #(.NUM_DOTS(NUM_DOTS)) u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dot_sel_i   (dot_sel),
    .lo_en_i     (lo_en),
    .hi_en_i     (hi_en),
    .lo_byte_i   (lo_byte),
    .hi_byte_i   (hi_byte),
    .live_i      (live),
    .frame_evt_i (frame_evt),
    .shadow_o    (shadow_flat),
    .active_o    (duty_o)
  );
endmodule

// File: rtl/frame_refresh_buf_chk.sv
module frame_refresh_buf_chk #(
  parameter int NUM_DOTS = 32,
  parameter int VS_MIN_W = 4,
  parameter int ADDR_W   = 6
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [1:0]             mode_i,
  input logic                   wr_en_i,
  input logic [ADDR_W-1:0]      wr_addr_i,
  input logic [7:0]             wr_data_i,
  input logic                   vsync_i,
  input logic [NUM_DOTS*16-1:0] duty_o,
  input logic [NUM_DOTS*16-1:0] shadow_flat,
  input logic                   frame_evt
);
  localparam int HW = $clog2(VS_MIN_W + 2);
  localparam logic [HW-1:0] HSAT = HW'(VS_MIN_W + 1);

  logic              wr_q, live_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic [HW-1:0]     hi_cnt_q, hi_cnt_d1_q;
  logic [15:0]       dot_val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= 1'b0; live_q <= 1'b0; addr_q <= '0; data_q <= '0;
      hi_cnt_q <= '0; hi_cnt_d1_q <= '0;
    end else begin
      wr_q   <= wr_en_i;
      live_q <= (mode_i == 2'd0) || (mode_i == 2'd1);
      addr_q <= wr_addr_i;
      data_q <= wr_data_i;
      hi_cnt_q <= !vsync_i ? '0 : (hi_cnt_q == HSAT) ? hi_cnt_q : hi_cnt_q + 1'b1;
      hi_cnt_d1_q <= hi_cnt_q;
    end
  end

  always_comb begin
    dot_val = '0;
    if (int'(addr_q) < NUM_DOTS) dot_val = duty_o[int'(addr_q)*16 +: 16];
  end

  // R2
  live_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_q && live_q && int'(addr_q) < NUM_DOTS) |-> dot_val == {data_q, 8'h00});

  // R4
  held_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == 2'd2 || mode_i == 2'd3) && !frame_evt) |=> $stable(duty_o));

  // R5
  frame_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_evt |=> duty_o == $past(shadow_flat));

  // R6
  evt_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_evt |-> hi_cnt_d1_q >= HW'(VS_MIN_W));

  // R6
  evt_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_evt |=> !frame_evt);
endmodule

bind frame_refresh_buf frame_refresh_buf_chk #(
  .NUM_DOTS(NUM_DOTS), .VS_MIN_W(VS_MIN_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .wr_data_i   (wr_data_i),
  .vsync_i     (vsync_i),
  .duty_o      (duty_o),
  .shadow_flat (shadow_flat),
  .frame_evt   (frame_evt)
);

// File: tb/frame_refresh_buf_bench.sv
module frame_refresh_buf_bench;
  localparam int N  = 32;
  localparam int W  = 4;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode = 2'd1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          vsync = 1'b0;
  logic [N*16-1:0] duty;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  logic [15:0] exp_sh [N];
  logic [15:0] exp_act[N];

  always #5 clk = ~clk;

  frame_refresh_buf u_frame_refresh_buf (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .vsync_i(vsync), .duty_o(duty)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  task automatic check_dot(input int d, input logic [15:0] e, input string req);
    tests++;
    if (duty[d*16 +: 16] !== e) begin
      fails++;
      $display("FAIL %s dot %0d actual %h expected %h", req, d, duty[d*16 +: 16], e);
    end
  endtask

  task automatic check_all(input string req);
    int bad = 0;
    tests++;
    for (int d = 0; d < N; d++) begin
      if (duty[d*16 +: 16] !== exp_act[d]) begin
        bad++;
        $display("FAIL %s dot %0d actual %h expected %h", req, d, duty[d*16 +: 16], exp_act[d]);
      end
    end
    if (bad != 0) fails++;
  endtask

  // model update for one write under the current mode
  task automatic model_write(input logic [AW-1:0] a, input logic [7:0] v);
    int d;
    if (mode == 2'd3) begin
      d = int'(a) >> 1;
      if (a[0]) exp_sh[d][15:8] = v; else exp_sh[d][7:0] = v;
    end else if (int'(a) < N) begin
      d = int'(a);
      exp_sh[d] = {v, 8'h00};
      if (mode <= 2'd1) exp_act[d] = {v, 8'h00};
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, v);
  endtask

  task automatic pulse_vsync(input int len);
    @(negedge clk);
    vsync = 1'b1;
    repeat (len) @(negedge clk);
    vsync = 1'b0;
    repeat (W + 4) @(negedge clk);
    if (len >= W && mode >= 2'd2)
      for (int d = 0; d < N; d++) exp_act[d] = exp_sh[d];
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    mode = m;
  endtask

  task automatic t_reset;
    for (int d = 0; d < N; d++) begin exp_sh[d] = '0; exp_act[d] = '0; end
    check_all("R1 in reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_all("R1 after reset");
  endtask

  task automatic t_live;
    set_mode(2'd1);
    do_write(6'd5, 8'hA7);
    check_dot(5, 16'hA700, "R2 live write");
    do_write(6'd31, 8'h3C);
    check_all("R3 only written dots change");
    set_mode(2'd0);
    do_write(6'd0, 8'h11);
    check_dot(0, 16'h1100, "R2 reserved mode acts live");
  endtask

  task automatic t_frame8;
    set_mode(2'd2);
    check_all("R8 mode switch keeps display");
    do_write(6'd3, 8'h5A);
    do_write(6'd40, 8'hFF);
    repeat (4) @(negedge clk);
    check_all("R4 framed writes held");
    pulse_vsync(W - 1);
    check_all("R6 short pulse ignored");
    pulse_vsync(W);
    check_dot(3, 16'h5A00, "R5 frame copy");
    check_dot(5, 16'hA700, "R8 live write kept in buffer");
    check_all("R10 out of range ignored");
  endtask

  task automatic t_frame16;
    set_mode(2'd3);
    do_write(6'd14, 8'h34);
    do_write(6'd15, 8'h12);
    do_write(6'd11, 8'hBE);
    check_all("R4 16-bit writes held");
    pulse_vsync(W + 2);
    check_dot(7, 16'h1234, "R7 16-bit byte assembly");
    check_dot(5, 16'hBE00, "R7 odd address writes high byte only");
    check_all("R5 16-bit frame copy");
  endtask

  task automatic t_live_vsync;
    set_mode(2'd2);
    do_write(6'd9, 8'h99);
    set_mode(2'd1);
    pulse_vsync(W + 3);
    check_dot(9, 16'h0000, "R9 vsync ignored in live mode");
    set_mode(2'd2);
    pulse_vsync(W);
    check_dot(9, 16'h9900, "R9 held data shows on next framed pulse");
  endtask

  task automatic t_collide;
    set_mode(2'd2);
    do_write(6'd11, 8'hC1);
    @(negedge clk);
    vsync = 1'b1;
    repeat (W + 1) @(posedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 6'd12; wr_data = 8'hD2;
    for (int d = 0; d < N; d++) exp_act[d] = exp_sh[d];
    @(negedge clk);
    wr_en = 1'b0;
    model_write(6'd12, 8'hD2);
    do_write(6'd13, 8'hE3);
    repeat (3) @(negedge clk);
    vsync = 1'b0;
    repeat (W + 4) @(negedge clk);
    check_dot(11, 16'hC100, "R11 copy on collision cycle");
    check_dot(12, 16'h0000, "R11 colliding write not in this frame");
    check_dot(13, 16'h0000, "R6 one copy per long pulse");
    pulse_vsync(W);
    check_dot(12, 16'hD200, "R11 colliding write in next frame");
    check_all("R5 frame after collision");
  endtask

  initial begin
    t_reset();
    t_live();
    t_frame8();
    t_frame16();
    t_live_vsync();
    t_collide();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule